// File: doc/BRIEF.md
# Four-Point Complex DFT Core (Multiplier-Free)

This core takes four complex samples and returns their four-point discrete Fourier transform, X(k) = sum over n of x(n)·e^(−j2πnk/4) for k = 0..3. Each input sample arrives as an 8-bit signed real part and an 8-bit signed imaginary part. Each result leaves as a 10-bit signed real part and a 10-bit signed imaginary part. Two extra bits cover four-operand growth, so no result ever wraps or saturates.

The only twiddle factors are +1, −1, +j and −j, so the core needs no multipliers. Each of the eight output components is one four-operand sum. Its operands are picked from the real or imaginary input parts, depending on the rotation. A subtracted operand is sign-extended and bitwise inverted. The missing "+1" of each two's-complement negation is folded into a single constant added at the end. Every sum runs through a per-bit (4,2) carry-save compressor and then one carry-propagate add.

A small two-state machine times the output. State `ST_IDLE` moves to `ST_EMIT` on a cycle with `in_valid` high (transition "accept"). `ST_EMIT` stays in `ST_EMIT` when another set is offered (transition "stream"). It returns to `ST_IDLE` when none is offered (transition "drain"). `out_valid` is high exactly while the state is `ST_EMIT`.

Top module: `dft4_core`

## Requirements
- R1: While and after reset, before any input is accepted, out_valid is 0 and every real and imaginary output part is 0.
- R2: Element k of out_re/out_im carries frequency bin k. Element n of in_re/in_im carries sample n. Bin 0 is the plain sum: Re X(0) = xr0+xr1+xr2+xr3 and Im X(0) = xi0+xi1+xi2+xi3.
- R3: Re X(1) = xr0 + xi1 − xr2 − xi3 and Im X(1) = xi0 − xr1 − xi2 + xr3.
- R4: Re X(2) = xr0 − xr1 + xr2 − xr3 and Im X(2) = xi0 − xi1 + xi2 − xi3.
- R5: Re X(3) = xr0 − xi1 − xr2 + xi3 and Im X(3) = xi0 + xr1 − xi2 − xr3.
- R6: out_valid is 1 in the cycle after each cycle with in_valid = 1, and 0 in the cycle after each cycle with in_valid = 0. This also holds for back-to-back sets, one result per accepted set.
- R7: While in_valid is 0, the output parts keep their last values, whatever the inputs do.
- R8: Inputs and outputs are signed two's complement, and results are exact at full scale. Example: all parts at −128 give Re X(0) = Im X(0) = −512 and all other parts 0. The limit case Re X(1) with xr0 = xi1 = 127 and xr2 = xi3 = −128 gives +510.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set present and accepted this cycle |
| in_re | input | 4x8 | Real parts of samples 0..3, element n = sample n |
| in_im | input | 4x8 | Imaginary parts of samples 0..3 |
| out_valid | output | 1 | Result set valid this cycle |
| out_re | output | 4x10 | Real parts of bins 0..3, element k = bin k |
| out_im | output | 4x10 | Imaginary parts of bins 0..3 |

## Verification
Each single input component is swept through all 256 values while the others stay zero. This impulse sweep shows which bins take that component, with which sign, and whether it lands in the real or the imaginary part, so a wrong swap or a missing inversion shows up directly. Uniform extremes (all −128, all +127) and the per-bin limit patterns exercise sign extension and the folded negation constant at full range. Random sets catch cross-term mistakes. Back-to-back and idle stretches separate the valid timing and the output-hold behaviour from the arithmetic.

// File: rtl/dft4_pkg.sv
package dft4_pkg;

    localparam int SAMPLES = 4;

    typedef enum logic {
        PART_RE = 1'b0,
        PART_IM = 1'b1
    } part_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

    typedef struct packed {
        logic take_im;
        logic negate;
    } operand_cfg_t;

    // Rotation index m = n*k mod 4 selects W^m in {1, -j, -1, +j}.
    function automatic operand_cfg_t pick_operand(input int k, input int part, input int n);
        operand_cfg_t cfg;
        int m;
        m = (n * k) % 4;
        if (part == 0) begin
            cfg.take_im = (m == 1) || (m == 3);
            cfg.negate  = (m == 2) || (m == 3);
        end else begin
            cfg.take_im = (m == 0) || (m == 2);
            cfg.negate  = (m == 1) || (m == 2);
        end
        return cfg;
    endfunction

    function automatic int negated_count(input int k, input int part);
        int cnt;
        operand_cfg_t c;
        cnt = 0;
        for (int n = 0; n < SAMPLES; n++) begin
            c = pick_operand(k, part, n);
            if (c.negate) cnt++;
        end
        return cnt;
    endfunction

endpackage

// File: rtl/dft4_operand_route.sv
module dft4_operand_route
    import dft4_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 10,
    parameter int BIN   = 0,
    parameter int PART  = 0
) (
    input  logic [SAMPLES-1:0][IN_W-1:0]  src_re,
    input  logic [SAMPLES-1:0][IN_W-1:0]  src_im,
    output logic [SAMPLES-1:0][OUT_W-1:0] operand
);
    localparam int EXT_W = OUT_W - IN_W;

    for (genvar n = 0; n < SAMPLES; n++) begin : g_op
        localparam operand_cfg_t CFG = pick_operand(BIN, PART, n);
        logic [IN_W-1:0]  picked;
        logic [OUT_W-1:0] widened;

        if (CFG.take_im) begin : g_im
            assign picked = src_im[n];
        end else begin : g_re
            assign picked = src_re[n];
        end

        assign widened = {{EXT_W{picked[IN_W-1]}}, picked};

        if (CFG.negate) begin : g_inv
            assign operand[n] = ~widened;
        end else begin : g_pass
            assign operand[n] = widened;
        end
    end
endmodule

// File: rtl/dft4_csa42.sv
module dft4_csa42 #(
    parameter int W = 10
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic [W-1:0] op_d,
    output logic [W-1:0] sum_vec,
    output logic [W-1:0] twice_vec
);
    logic [W-1:0] hop;
    logic [W-1:0] stage1;

    assign hop[0]       = 1'b0;
    assign twice_vec[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign stage1[i]  = op_a[i] ^ op_b[i] ^ op_c[i];
        assign sum_vec[i] = stage1[i] ^ op_d[i] ^ hop[i];
        if (i < W - 1) begin : g_carry
            assign hop[i+1] = (op_a[i] & op_b[i]) | (op_a[i] & op_c[i]) | (op_b[i] & op_c[i]);
            assign twice_vec[i+1] = (stage1[i] & op_d[i]) | (stage1[i] & hop[i]) | (op_d[i] & hop[i]);
        end
    end
endmodule

// File: rtl/dft4_sum4.sv
module dft4_sum4
    import dft4_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 10,
    parameter int BIN   = 0,
    parameter int PART  = 0
) (
    input  logic [SAMPLES-1:0][IN_W-1:0] src_re,
    input  logic [SAMPLES-1:0][IN_W-1:0] src_im,
    output logic [OUT_W-1:0]             result
);
    localparam int NEG_CNT = negated_count(BIN, PART);
    localparam logic [OUT_W-1:0] FIXUP = OUT_W'(NEG_CNT);

    logic [SAMPLES-1:0][OUT_W-1:0] operand;
    logic [OUT_W-1:0] sum_vec;
    logic [OUT_W-1:0] twice_vec;

    dft4_operand_route #(
        .IN_W (IN_W),
        .OUT_W(OUT_W),
        .BIN  (BIN),
        .PART (PART)
    ) route_i (
        .src_re (src_re),
        .src_im (src_im),
        .operand(operand)
    );

    dft4_csa42 #(.W(OUT_W)) csa_i (
        .op_a     (operand[0]),
        .op_b     (operand[1]),
        .op_c     (operand[2]),
        .op_d     (operand[3]),
        .sum_vec  (sum_vec),
        .twice_vec(twice_vec)
    );

    assign result = sum_vec + twice_vec + FIXUP;
endmodule

// File: rtl/dft4_core.sv
module dft4_core
    import dft4_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [SAMPLES-1:0][IN_W-1:0]  in_re,
    input  logic [SAMPLES-1:0][IN_W-1:0]  in_im,
    output logic                          out_valid,
    output logic [SAMPLES-1:0][OUT_W-1:0] out_re,
    output logic [SAMPLES-1:0][OUT_W-1:0] out_im
);
    emit_state_e state_q;
    emit_state_e state_d;

    logic [SAMPLES-1:0][OUT_W-1:0] bin_re;
    logic [SAMPLES-1:0][OUT_W-1:0] bin_im;

    for (genvar k = 0; k < SAMPLES; k++) begin : g_bin
        dft4_sum4 #(
            .IN_W (IN_W),
            .OUT_W(OUT_W),
            .BIN  (k),
            .PART (0)
        ) re_sum_i (
            .src_re(in_re),
            .src_im(in_im),
            .result(bin_re[k])
        );

        dft4_sum4 #(
            .IN_W (IN_W),
            .OUT_W(OUT_W),
            .BIN  (k),
            .PART (1)
        ) im_sum_i (
            .src_re(in_re),
            .src_im(in_im),
            .result(bin_im[k])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_re <= '0;
            out_im <= '0;
        end else if (in_valid) begin
            out_re <= bin_re;
            out_im <= bin_im;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/dft4_core_chk.sv
module dft4_core_chk
    import dft4_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [SAMPLES-1:0][IN_W-1:0]  in_re,
    input  logic [SAMPLES-1:0][IN_W-1:0]  in_im,
    input  logic                          out_valid,
    input  logic [SAMPLES-1:0][OUT_W-1:0] out_re,
    input  logic [SAMPLES-1:0][OUT_W-1:0] out_im
);
    logic [OUT_W-1:0] dc_re_ref;
    logic [OUT_W-1:0] alt_im_ref;

    assign dc_re_ref = OUT_W'($signed(in_re[0])) + OUT_W'($signed(in_re[1]))
                     + OUT_W'($signed(in_re[2])) + OUT_W'($signed(in_re[3]));
    assign alt_im_ref = OUT_W'($signed(in_im[0])) - OUT_W'($signed(in_im[1]))
                      + OUT_W'($signed(in_im[2])) - OUT_W'($signed(in_im[3]));

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_re) && $stable(out_im)));

    // R2
    dc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_re[0] == $past(dc_re_ref)));

    // R4
    alt_im_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_im[2] == $past(alt_im_ref)));
endmodule

bind dft4_core dft4_core_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_re    (in_re),
    .in_im    (in_im),
    .out_valid(out_valid),
    .out_re   (out_re),
    .out_im   (out_im)
);

// File: tb/dft4_core_tb_top.sv
module dft4_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 8;
    localparam int OUT_W = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [3:0][IN_W-1:0]  in_re = '0;
    logic [3:0][IN_W-1:0]  in_im = '0;
    logic                  out_valid;
    logic [3:0][OUT_W-1:0] out_re;
    logic [3:0][OUT_W-1:0] out_im;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int xr[4];
    int xi[4];
    int pr[4];
    int pi[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dft4_core #(.IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_re    (in_re),
        .in_im    (in_im),
        .out_valid(out_valid),
        .out_re   (out_re),
        .out_im   (out_im)
    );

    function automatic int ref_bin(input int ar[4], input int ai[4], input int k, input bit im);
        int cr[4] = '{1, 0, -1, 0};
        int ci[4] = '{0, -1, 0, 1};
        int acc = 0;
        for (int n = 0; n < 4; n++) begin
            int m = (n * k) % 4;
            if (im) acc += ar[n] * ci[m] + ai[n] * cr[m];
            else    acc += ar[n] * cr[m] - ai[n] * ci[m];
        end
        return acc;
    endfunction

    task automatic check_val(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string bin_req(input int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_bins(input int ar[4], input int ai[4]);
        for (int k = 0; k < 4; k++) begin
            check_val(bin_req(k), $sformatf("re X(%0d)", k),
                      int'($signed(out_re[k])), ref_bin(ar, ai, k, 1'b0));
            check_val(bin_req(k), $sformatf("im X(%0d)", k),
                      int'($signed(out_im[k])), ref_bin(ar, ai, k, 1'b1));
        end
    endtask

    task automatic drive_set();
        for (int n = 0; n < 4; n++) begin
            in_re[n] = IN_W'(xr[n]);
            in_im[n] = IN_W'(xi[n]);
        end
    endtask

    // Drive on the falling edge, check one cycle later on the next falling edge.
    task automatic run_one();
        drive_set();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_val("R6", "out_valid after accept", int'(out_valid), 1);
        check_bins(xr, xi);
    endtask

    task automatic set_all(input int v);
        for (int n = 0; n < 4; n++) begin
            xr[n] = v;
            xi[n] = v;
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R1: reset state
        check_val("R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1", "out_valid after reset", int'(out_valid), 0);
        for (int k = 0; k < 4; k++) begin
            check_val("R1", "re after reset", int'($signed(out_re[k])), 0);
            check_val("R1", "im after reset", int'($signed(out_im[k])), 0);
        end

        // Impulse sweep: one component through all values, the rest zero (R2..R5)
        for (int n = 0; n < 4; n++) begin
            for (int part = 0; part < 2; part++) begin
                for (int v = -128; v < 128; v++) begin
                    set_all(0);
                    if (part == 0) xr[n] = v;
                    else           xi[n] = v;
                    run_one();
                end
            end
        end

        // R8: full-scale uniform extremes
        set_all(-128);
        run_one();
        check_val("R8", "re X(0) all min", int'($signed(out_re[0])), -512);
        set_all(127);
        run_one();
        check_val("R8", "im X(0) all max", int'($signed(out_im[0])), 508);
        // R8: limit pattern for re X(1)
        set_all(0);
        xr[0] = 127; xi[1] = 127; xr[2] = -128; xi[3] = -128;
        run_one();
        check_val("R8", "re X(1) limit", int'($signed(out_re[1])), 510);
        // R8: alternating extremes for bin 2
        for (int n = 0; n < 4; n++) begin
            xr[n] = (n % 2 == 0) ? 127 : -128;
            xi[n] = (n % 2 == 0) ? -128 : 127;
        end
        run_one();

        // Random sets
        for (int t = 0; t < 600; t++) begin
            for (int n = 0; n < 4; n++) begin
                xr[n] = int'($urandom_range(255)) - 128;
                xi[n] = int'($urandom_range(255)) - 128;
            end
            run_one();
        end

        // R6: back-to-back sets, one result per set
        for (int t = 0; t < 20; t++) begin
            for (int n = 0; n < 4; n++) begin
                xr[n] = int'($urandom_range(255)) - 128;
                xi[n] = int'($urandom_range(255)) - 128;
            end
            drive_set();
            in_valid = 1'b1;
            if (t > 0) begin
                pr = xr; pi = xi;
            end
            @(negedge clk);
            check_val("R6", "out_valid streaming", int'(out_valid), 1);
            check_bins(xr, xi);
        end
        in_valid = 1'b0;
        pr = xr;
        pi = xi;

        // R7 and R6: idle cycles with changing inputs
        for (int t = 0; t < 5; t++) begin
            for (int n = 0; n < 4; n++) begin
                in_re[n] = IN_W'($urandom_range(255));
                in_im[n] = IN_W'($urandom_range(255));
            end
            @(negedge clk);
            check_val("R6", "out_valid idle", int'(out_valid), 0);
            for (int k = 0; k < 4; k++) begin
                check_val("R7", "re held", int'($signed(out_re[k])), ref_bin(pr, pi, k, 1'b0));
                check_val("R7", "im held", int'($signed(out_im[k])), ref_bin(pr, pi, k, 1'b1));
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule